// File: doc/BRIEF.md
# Four-Channel Wiper Register SPI Slave

This block is the digital control core of a four-channel, 256-step potentiometer. A host talks to it over a 16-bit SPI frame carried in one chip-select window. Each frame holds a 4-bit command, a 4-bit channel address and an 8-bit data byte. The block keeps four 8-bit wiper position registers, which drive the analog resistor strings outside this block.

The SPI pins are brought into the system clock domain through two-flop synchronisers, and every edge is detected there. Bits are shifted in on serial-clock falling edges. A frame takes effect only when the select line goes back high, and only if it held exactly sixteen falling edges. While a frame is in progress, the serial output shifts out the word accepted in the previous valid frame, most significant bit first, so a host can read back state or chain several devices. The output is open-drain: the block only pulls the pin low or lets it go, and it lets go as soon as select rises.

Top module: `quad_wiper_spi`

## Requirements
- R1: After reset all four wipers hold 0x80, the serial output is released (`sdo_en` low), and the echo word is zero, so the first frame shifts out sixteen zero bits.
- R2: A frame is 16 bits, MSB first: bits 15:12 are the command, 11:8 the address, 7:0 the data. Command 0x1 with address 0..3 loads the data byte into wiper 0..3, and no other wiper changes.
- R3: Command 0x1 with address 0x8 loads the data byte into all four wipers.
- R4: Wiper values change only after the select line returns high. While select is low, no wiper changes.
- R5: A frame with any number of serial-clock falling edges other than sixteen is discarded. No wiper changes and the echo word keeps its previous value.
- R6: During a frame, the serial output presents the previous valid 16-bit frame, bit 15 first, one bit per serial-clock period.
- R7: After a valid frame with command 0x3 and address 0..3, the next frame's echo carries bits 15:8 of that frame followed by the addressed wiper value in bits 7:0. With any other address, the frame is echoed unchanged.
- R8: `sdo_en` is high while a frame is in progress and goes low a few system clocks after select rises.
- R9: Both serial-clock idle polarities work: idle-low with data launched on the first rising edge, and idle-high with the first bit valid at select fall. In both cases input is sampled on falling edges.
- R10: Command 0x0, any command other than 0x1 or 0x3, and a write to an address other than 0..3 or 0x8 leave all wipers unchanged.
- R11: The serial output bit changes only after a serial-clock rising edge that follows at least one falling edge in the frame, or when the echo word is loaded at select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sync_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo_q | output | 1 | Serial data bit; the pad pulls low when `sdo_en` is high and this bit is 0 |
| sdo_en | output | 1 | High while the block may pull the open-drain pin low |
| wipers | output | 4x8 | Packed wiper positions, index 0..3 |

## Verification
The assertions assume that the serial clock and select are slow enough for the two-flop synchronisers, so each pin level is held for several system clocks. They also assume that select never changes in the same synchronised cycle as a serial-clock edge. The bench drives each serial-clock half period for six system clocks and places select transitions half a period away from any clock edge. It covers both idle polarities, and it sends short and long frames to check that they are discarded.

// File: rtl/qw_pkg.sv
// Shared constants and command codes for the wiper register SPI slave.
// Assumes a frame of command, address and data fields, in that order from the MSB.
package qw_pkg;
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP   = 4'h0,
        CMD_WRITE = 4'h1,
        CMD_READ  = 4'h3
    } qw_cmd_e;

    localparam logic [ADDR_W-1:0] ADDR_ALL = 4'h8;
    localparam logic [DATA_W-1:0] WIPER_MID = 8'h80;
endpackage

// File: rtl/qw_sync.sv
// Two-flop synchroniser bank for asynchronous serial pins.
// Assumes each pin level is held for at least two system clocks.
module qw_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages per pin against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/qw_frame.sv
// Edge detection and frame assembly in the system clock domain.
// Shifts SDI in on serial-clock falls while select is low, counts the falls,
// and issues a one-cycle commit pulse with the word on select rise when the
// count is exactly FRAME_W. Assumes select and clock edges never coincide.
module qw_frame
    import qw_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    output logic          cs_fall,
    output logic          cs_rise,
    output logic          shift_ok,
    output logic          commit,
    output logic [FW-1:0] frame_word
);
    localparam int CNT_W = $clog2(FW + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FW + 1);
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FW);

    logic             cs_d;
    logic             sclk_d;
    logic [FW-1:0]    rx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sclk_fall;

    // Previous synchronised levels, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d & ~cs_s;
    assign cs_rise   = ~cs_d & cs_s;
    assign sclk_fall = sclk_d & ~sclk_s & ~cs_s;
    // A rise only launches a new bit once the frame has sampled one.
    assign shift_ok  = ~sclk_d & sclk_s & ~cs_s & (cnt_q != '0);

    // Receive shift register and saturating fall counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (cs_fall) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (sclk_fall) begin
            rx_q  <= {rx_q[FW-2:0], sdi_s};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Commit pulse and held word, issued one cycle after select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit     <= 1'b0;
            frame_word <= '0;
        end else begin
            commit <= cs_rise && (cnt_q == CNT_GOOD);
            if (cs_rise) frame_word <= rx_q;
        end
    end
endmodule

// File: rtl/qw_bank.sv
// Wiper register bank and echo word.
// Decodes a committed frame: writes one or all wipers, and builds the word to
// be echoed in the next frame (readback replaces the data byte).
module qw_bank
    import qw_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = DATA_W,
    parameter int FW  = FRAME_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [FW-1:0]           frame_word,
    output logic [NCH-1:0][DW-1:0]  wipers,
    output logic [FW-1:0]           echo
);
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DW-1:0]     data;
    logic              addr_in_range;
    logic [DW-1:0]     read_val;

    assign cmd  = frame_word[FW-1 -: CMD_W];
    assign addr = frame_word[DW +: ADDR_W];
    assign data = frame_word[DW-1:0];
    assign addr_in_range = (int'(addr) < NCH);

    // One register per channel, loaded on a matching write.
    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_wiper
            logic hit;
            assign hit = commit && (cmd == CMD_WRITE) &&
                         ((addr == ADDR_W'(ch)) || (addr == ADDR_ALL));
            // Per-channel wiper storage.
            always_ff @(posedge clk) begin
                if (!rst_n)   wipers[ch] <= WIPER_MID;
                else if (hit) wipers[ch] <= data;
            end
        end
    endgenerate

    // Readback multiplexer over the current wiper values.
    always_comb begin
        read_val = '0;
        for (int i = 0; i < NCH; i++)
            if (addr[SEL_W-1:0] == SEL_W'(i)) read_val = wipers[i];
    end

    // Echo word held for the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo <= '0;
        end else if (commit) begin
            if ((cmd == CMD_READ) && addr_in_range)
                echo <= {frame_word[FW-1:DW], read_val};
            else
                echo <= frame_word;
        end
    end
endmodule

// File: rtl/qw_sdo.sv
// Serial output shifter with open-drain enable.
// Loads the echo word at select fall, advances on gated rising edges, and
// releases the pin on select rise.
module qw_sdo
    import qw_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          shift_ok,
    input  logic [FW-1:0] echo,
    output logic          sdo_q,
    output logic          sdo_en
);
    logic [FW-1:0] tx_q;

    // Transmit shift register and drive-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            sdo_en <= 1'b0;
        end else if (cs_fall) begin
            tx_q   <= echo;
            sdo_en <= 1'b1;
        end else if (cs_rise) begin
            sdo_en <= 1'b0;
        end else if (shift_ok) begin
            tx_q <= {tx_q[FW-2:0], 1'b0};
        end
    end

    assign sdo_q = tx_q[FW-1];
endmodule

// File: rtl/quad_wiper_spi.sv
// Top level of the four-channel wiper register SPI slave.
// Assumes clk runs at least four times the serial clock rate; all pins are
// asynchronous to clk and pass through the synchroniser bank.
module quad_wiper_spi
    import qw_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_n,
    input  logic                   sclk,
    input  logic                   sdi,
    output logic                   sdo_q,
    output logic                   sdo_en,
    output logic [NCH-1:0][DW-1:0] wipers
);
    localparam int FW = CMD_W + ADDR_W + DW;

    logic          cs_s, sclk_s, sdi_s;
    logic          cs_fall, cs_rise, shift_ok, commit;
    logic [FW-1:0] frame_word;
    logic [FW-1:0] echo;

    qw_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sync_n, sclk, sdi}),
        .d_sync  ({cs_s, sclk_s, sdi_s})
    );

    qw_frame #(.FW(FW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_s       (cs_s),
        .sclk_s     (sclk_s),
        .sdi_s      (sdi_s),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .shift_ok   (shift_ok),
        .commit     (commit),
        .frame_word (frame_word)
    );

    qw_bank #(.NCH(NCH), .DW(DW), .FW(FW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .frame_word (frame_word),
        .wipers     (wipers),
        .echo       (echo)
    );

    qw_sdo #(.FW(FW)) u_sdo (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .shift_ok (shift_ok),
        .echo     (echo),
        .sdo_q    (sdo_q),
        .sdo_en   (sdo_en)
    );
endmodule

// File: rtl/qw_checker.sv
// Property checker for quad_wiper_spi, bound to every instance of the top.
// Relates the frame unit's commit pulse, the bank's wipers and the serial
// output, across module boundaries.
module qw_checker #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int FW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   commit,
    input logic [FW-1:0]          frame_word,
    input logic [NCH-1:0][DW-1:0] wipers,
    input logic                   cs_s,
    input logic                   cs_fall,
    input logic                   shift_ok,
    input logic                   sdo_q,
    input logic                   sdo_en
);
    // Wipers move only in the cycle after a commit pulse.
    assert_commit_gates_wipers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> $stable(wipers));

    // Serial bit moves only after a gated rise or a load.
    assert_sdo_moves_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> $past(shift_ok || cs_fall));

    // Pin released the cycle after select is seen high.
    assert_release_on_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_en);

    // Broadcast write lands in every channel.
    assert_broadcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && frame_word[FW-1 -: 4] == 4'h1 && frame_word[DW +: 4] == 4'h8)
        |=> (wipers == {NCH{$past(frame_word[DW-1:0])}}));

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_chk
            // Single-channel write lands in the addressed wiper.
            assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (commit && frame_word[FW-1 -: 4] == 4'h1 && frame_word[DW +: 4] == 4'(ch))
                |=> (wipers[ch] == $past(frame_word[DW-1:0])));
        end
    endgenerate
endmodule

bind quad_wiper_spi qw_checker #(.NCH(NCH), .DW(DW), .FW(FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .frame_word (frame_word),
    .wipers     (wipers),
    .cs_s       (cs_s),
    .cs_fall    (cs_fall),
    .shift_ok   (shift_ok),
    .sdo_q      (sdo_q),
    .sdo_en     (sdo_en)
);

// File: tb/sim_quad_wiper_spi.sv
// Bench: behavioural host plus reference model, wipers compared every clock.
module sim_quad_wiper_spi;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo_q, sdo_en;
    logic [3:0][7:0] wipers;

    int checks = 0;
    int errors = 0;
    int settle = 0;
    bit done = 0;
    logic [7:0]  exp_w [4];
    logic [15:0] exp_echo;

    always #2 clk = ~clk;

    quad_wiper_spi u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
        .sdo_q(sdo_q), .sdo_en(sdo_en), .wipers(wipers)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of wipers against the model (R4: no early change).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (settle > 0) settle--;
            else
                for (int i = 0; i < 4; i++)
                    check(wipers[i] === exp_w[i], "R4 wiper tracks model", wipers[i], exp_w[i]);
        end
    end

    // Model update on a committed frame.
    task automatic model_commit(input logic [15:0] w);
        logic [3:0] c;
        logic [3:0] a;
        c = w[15:12];
        a = w[11:8];
        if (c == 4'h3 && a < 4) exp_echo = {w[15:8], exp_w[a]};
        else exp_echo = w;
        if (c == 4'h1) begin
            if (a < 4) exp_w[a] = w[7:0];
            else if (a == 4'h8) for (int i = 0; i < 4; i++) exp_w[i] = w[7:0];
        end
    endtask

    // One frame of nbits bits in either idle polarity; checks echo and release.
    task automatic send(input logic [15:0] w, input int nbits, input bit cpol, input string tag);
        logic [15:0] cap;
        logic [15:0] want;
        cap = '0;
        want = exp_echo;
        sclk = cpol;
        wait_clks(HALF);
        sync_n = 1'b0;
        if (cpol) sdi = w[15];
        wait_clks(HALF);
        check(sdo_en === 1'b1, "R8 enabled in frame", sdo_en, 1);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i < 16) ? w[15-i] : 1'b0;
            if (!cpol) begin
                sclk = 1'b1;
                sdi = b;
                wait_clks(HALF);
            end
            if (i < 16) cap[15-i] = (sdo_en && !sdo_q) ? 1'b0 : 1'b1;
            sclk = 1'b0;
            wait_clks(HALF);
            if (cpol) begin
                sclk = 1'b1;
                sdi = (i + 1 < 16) ? w[14-i] : 1'b0;
                wait_clks(HALF);
            end
        end
        wait_clks(HALF);
        sync_n = 1'b1;
        settle = 8;
        if (nbits == 16) begin
            check(cap === want, tag, cap, want);
            model_commit(w);
        end
        wait_clks(10);
        check(sdo_en === 1'b0, "R8 released after select", sdo_en, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_w[i] = 8'h80;
        exp_echo = 16'h0000;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        // R1 reset state
        for (int i = 0; i < 4; i++)
            check(wipers[i] === 8'h80, "R1 reset midscale", wipers[i], 8'h80);
        check(sdo_en === 1'b0, "R1 output released", sdo_en, 0);
        send(16'h1012, 16, 1'b0, "R1 R6 R9 first echo zero");
        check(wipers[0] === 8'h12, "R2 write ch0", wipers[0], 8'h12);
        send(16'h12A5, 16, 1'b1, "R6 R9 echo idle-high");
        check(wipers[2] === 8'hA5, "R2 R9 write ch2", wipers[2], 8'hA5);
        send(16'h183C, 16, 1'b0, "R6 echo");
        for (int i = 0; i < 4; i++)
            check(wipers[i] === 8'h3C, "R3 broadcast", wipers[i], 8'h3C);
        send(16'h11F0, 16, 1'b1, "R6 echo");
        send(16'h3100, 16, 1'b0, "R6 echo before read");
        send(16'h0055, 16, 1'b1, "R7 readback ch1");
        // R5: short and long frames discarded
        send(16'h1377, 10, 1'b0, "R5 short");
        send(16'h1366, 17, 1'b1, "R5 long");
        check(wipers[3] === 8'h3C, "R5 wiper kept", wipers[3], 8'h3C);
        send(16'h0000, 16, 1'b0, "R5 echo kept");
        // R10: ignored writes
        send(16'h1577, 16, 1'b1, "R6 echo");
        send(16'h7099, 16, 1'b0, "R6 echo");
        check(wipers[0] === 8'h3C, "R10 ignored", wipers[0], 8'h3C);
        send(16'h3300, 16, 1'b1, "R10 echo");
        send(16'h3944, 16, 1'b0, "R7 readback ch3");
        send(16'h1300, 16, 1'b1, "R7 out-of-range read echoed");
        check(wipers[3] === 8'h00, "R2 boundary zero", wipers[3], 8'h00);
        send(16'h13FF, 16, 1'b0, "R6 echo");
        check(wipers[3] === 8'hFF, "R2 boundary full", wipers[3], 8'hFF);
        send(16'h3300, 16, 1'b1, "R6 echo");
        send(16'h0000, 16, 1'b0, "R7 R11 readback full scale");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #600000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule